// File: doc/BRIEF.md
# Pipeline Dependency Resolver

This unit watches the instruction sitting in decode of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) and decides, in the same cycle, how each of its two source operands is obtained. It compares the decode-stage source indices with the destination index, write-enable and load flag of the instructions now in execute, memory and write-back. The result is a forwarding select for each operand, or a one-cycle hold when the producer is a load still in execute.

A hold freezes the program counter and the fetch/decode register and pushes a bubble into execute. The pipeline then sees the same decode instruction again one cycle later, with the load moved on to memory where its data can be forwarded. A control transfer resolved in decode raises a redirect. The unit answers with a one-cycle clear of the fetch/decode register, so the wrongly fetched instruction becomes a NOP. A redirect overrides any hold requested in the same cycle.

The register file, the ALU and the branch comparison live outside. The unit only sees 5-bit indices taken from instruction bits 25-21 (first source), 20-16 (second source) and the decoded destination, plus control flags.

Top module: `dep_resolver`

## Requirements
- R1: While `rst` is high, every output is 0, whatever the other inputs are.
- R2: Register index 0 never causes forwarding or a hold. A source index of 0 gives select 0, and a producer whose destination is 0 is ignored.
- R3: Each operand select uses the code 0 = register file, 1 = execute-stage result, 2 = memory-stage result, 3 = write-back result. A producer matches only if its write-enable is set, its destination equals the source index, and that operand's use flag is set.
- R4: When more than one stage matches, the newest result wins: execute over memory over write-back, so memory beats write-back.
- R5: A load in execute is never selected as a forwarding source. The select falls through to a matching memory or write-back result, or to 0.
- R6: A hold is raised when the execute instruction is a load with write-enable set whose destination matches a used, nonzero source in decode. The hold drives `pc_hold`, `ifid_hold` and `ex_bubble` high together in that cycle.
- R7: When the surrounding pipeline honours the bubble, a hold never lasts more than one cycle. A dependent instruction waits exactly one clock.
- R8: `redirect` drives `ifid_flush` high in the same cycle and forces the three hold outputs low, even when a load hazard is present.
- R9: A matching non-load result in execute is forwarded (select 1) without any hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs | input | 5 | First source index of the decode instruction |
| id_rt | input | 5 | Second source index of the decode instruction |
| id_rs_used | input | 1 | First source is read by the decode instruction |
| id_rt_used | input | 1 | Second source is read by the decode instruction |
| ex_rd | input | 5 | Destination index in execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination index in memory stage |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination index in write-back |
| wb_wen | input | 1 | Write-back instruction writes a register |
| redirect | input | 1 | Taken control transfer resolved in decode |
| fwd_a | output | 2 | Source select for the first operand |
| fwd_b | output | 2 | Source select for the second operand |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the fetch/decode register |
| ex_bubble | output | 1 | Load a NOP into execute |
| ifid_flush | output | 1 | Clear the fetch/decode register to a NOP |

## Verification
Every decision is combinational from the current stage flags, so a wrong comparison or priority shows at the select or hold ports in the very cycle the hazard pattern appears. A wrong priority shows as the older stage's code, and a dropped load test shows as select 1 with no hold. A hold that fails to clear, or a missing bubble, shows one cycle later as a second consecutive hold once the pipeline has moved the load on. The bench runs a pipeline model that advances, holds and flushes as the requirements dictate, and compares all six outputs on every cycle.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } fwd_src_e;
endpackage

// File: rtl/dr_operand_match.sv
module dr_operand_match
  import dr_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] src,
  input  logic          used,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output fwd_src_e      sel,
  output logic          load_hit
);
  localparam logic [AW-1:0] ZERO_IDX = '0;

  logic live;
  logic hit_ex, hit_mem, hit_wb;

  assign live    = used && (src != ZERO_IDX);
  assign hit_ex  = live && ex_wen  && (ex_rd  == src);
  assign hit_mem = live && mem_wen && (mem_rd == src);
  assign hit_wb  = live && wb_wen  && (wb_rd  == src);

  always_comb begin
    if (hit_ex && !ex_load) sel = SRC_EX;
    else if (hit_mem)       sel = SRC_MEM;
    else if (hit_wb)        sel = SRC_WB;
    else                    sel = SRC_RF;
  end

  assign load_hit = hit_ex && ex_load;

  // R2: index zero is never a dependency
  p_zero_src_r2: assert property (@(posedge clk) disable iff (rst)
    (src == ZERO_IDX) |-> (sel == SRC_RF && !load_hit));

  // R5: a load in execute is not a forwarding source
  p_load_not_ex_r5: assert property (@(posedge clk) disable iff (rst)
    ex_load |-> (sel != SRC_EX));

  // R4: memory result beats write-back when execute does not match
  p_mem_over_wb_r4: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_WB) |-> !(mem_wen && mem_rd == src));
endmodule

// File: rtl/dr_hazard_ctrl.sv
module dr_hazard_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic stall_req,
  input  logic redirect,
  output logic pc_hold,
  output logic ifid_hold,
  output logic ex_bubble,
  output logic ifid_flush
);
  logic hold_w;
  logic held_q;

  assign hold_w     = !rst && stall_req && !redirect;
  assign pc_hold    = hold_w;
  assign ifid_hold  = hold_w;
  assign ex_bubble  = hold_w;
  assign ifid_flush = !rst && redirect;

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= hold_w;
  end

  // R7: a hold is never repeated on the next cycle
  p_single_stall_r7: assert property (@(posedge clk) disable iff (rst)
    held_q |-> !pc_hold);

  // R8: redirect wins over a hold
  p_flush_wins_r8: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (ifid_flush && !pc_hold && !ex_bubble));
endmodule

// File: rtl/dep_resolver.sv
module dep_resolver
  import dr_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_rs_used,
  input  logic          id_rt_used,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic          redirect,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ex_bubble,
  output logic          ifid_flush
);
  localparam int NSRC = 2;

  logic [AW-1:0] src_idx [NSRC];
  logic          src_use [NSRC];
  fwd_src_e      src_sel [NSRC];
  logic [NSRC-1:0] load_hits;

  assign src_idx[0] = id_rs;
  assign src_idx[1] = id_rt;
  assign src_use[0] = id_rs_used;
  assign src_use[1] = id_rt_used;

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    dr_operand_match #(.AW(AW)) u_match (
      .clk      (clk),
      .rst      (rst),
      .src      (src_idx[g]),
      .used     (src_use[g]),
      .ex_rd    (ex_rd),
      .ex_wen   (ex_wen),
      .ex_load  (ex_load),
      .mem_rd   (mem_rd),
      .mem_wen  (mem_wen),
      .wb_rd    (wb_rd),
      .wb_wen   (wb_wen),
      .sel      (src_sel[g]),
      .load_hit (load_hits[g])
    );
  end

  assign fwd_a = rst ? 2'd0 : src_sel[0];
  assign fwd_b = rst ? 2'd0 : src_sel[1];

  dr_hazard_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .stall_req  (|load_hits),
    .redirect   (redirect),
    .pc_hold    (pc_hold),
    .ifid_hold  (ifid_hold),
    .ex_bubble  (ex_bubble),
    .ifid_flush (ifid_flush)
  );

  // R9 / R6: a hold only ever comes from a writing load in execute
  p_hold_needs_load_r9: assert property (@(posedge clk) disable iff (rst)
    pc_hold |-> (ex_load && ex_wen));

  // R6: the hold reaches all three stage controls together
  p_hold_all_r6: assert property (@(posedge clk) disable iff (rst)
    ex_bubble |-> (pc_hold && ifid_hold && !ifid_flush));
endmodule

// File: tb/sim_dep_resolver.sv
module sim_dep_resolver;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] id_rs = 0, id_rt = 0, ex_rd = 0, mem_rd = 0, wb_rd = 0;
  logic id_rs_used = 0, id_rt_used = 0, ex_wen = 0, ex_load = 0;
  logic mem_wen = 0, wb_wen = 0, redirect = 0;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, ex_bubble, ifid_flush;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dep_resolver u0 (
    .clk(clk), .rst(rst), .id_rs(id_rs), .id_rt(id_rt),
    .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
    .redirect(redirect), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ex_bubble(ex_bubble),
    .ifid_flush(ifid_flush));

  // pick the newest usable producer for one source
  function automatic logic [1:0] pick(input logic [4:0] s, input logic u);
    int rd[3];
    bit we[3];
    rd[0] = ex_rd; rd[1] = mem_rd; rd[2] = wb_rd;
    we[0] = ex_wen; we[1] = mem_wen; we[2] = wb_wen;
    if (!u || s == 0) return 2'd0;
    for (int k = 0; k < 3; k++) begin
      if (we[k] && rd[k] == int'(s) && !(k == 0 && ex_load))
        return 2'(k + 1);
    end
    return 2'd0;
  endfunction

  function automatic logic [7:0] expect_now();
    bit lh;
    bit hold;
    if (rst) return 8'h00;
    lh = ex_load && ex_wen &&
         ((id_rs_used && id_rs != 0 && id_rs == ex_rd) ||
          (id_rt_used && id_rt != 0 && id_rt == ex_rd));
    hold = lh && !redirect;
    return {pick(id_rs, id_rs_used), pick(id_rt, id_rt_used),
            hold, hold, hold, redirect};
  endfunction

  task automatic check(input string tag);
    logic [7:0] act, exp;
    act = {fwd_a, fwd_b, pc_hold, ifid_hold, ex_bubble, ifid_flush};
    exp = expect_now();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] rs, input logic ru, input logic [4:0] rt,
                       input logic tu, input logic [4:0] erd, input logic ew,
                       input logic el, input logic [4:0] mrd, input logic mw,
                       input logic [4:0] wrd, input logic ww, input logic rdr);
    id_rs = rs; id_rs_used = ru; id_rt = rt; id_rt_used = tu;
    ex_rd = erd; ex_wen = ew; ex_load = el;
    mem_rd = mrd; mem_wen = mw; wb_rd = wrd; wb_wen = ww; redirect = rdr;
  endtask

  // pipeline model state: {rs, rt, rs_used, rt_used, rd, wen, load}
  typedef struct packed {
    logic [4:0] rs, rt;
    logic ru, tu;
    logic [4:0] rd;
    logic we, ld;
  } ins_t;

  function automatic ins_t rnd_ins();
    ins_t i;
    i.rs = 5'($urandom_range(0, 6));
    i.rt = 5'($urandom_range(0, 6));
    i.ru = 1'($urandom_range(0, 3) != 0);
    i.tu = 1'($urandom_range(0, 1));
    i.rd = 5'($urandom_range(0, 6));
    i.we = 1'($urandom_range(0, 4) != 0);
    i.ld = i.we && ($urandom_range(0, 2) == 0);
    return i;
  endfunction

  initial begin
    ins_t dec, ex, mem, wb;
    bit prev_hold;
    // R1: reset hides a full hazard pattern
    @(negedge clk);
    drive(5'd3, 1, 5'd4, 1, 5'd3, 1, 1, 5'd4, 1, 5'd3, 1, 1);
    #1 check("R1");
    @(negedge clk); rst = 1'b0;
    // R3: no match anywhere
    drive(5'd1, 1, 5'd2, 1, 5'd5, 1, 0, 5'd6, 1, 5'd7, 1, 0);
    #1 check("R3");
    @(negedge clk); // R3/R9: ALU result in execute forwarded, no hold
    drive(5'd5, 1, 5'd2, 1, 5'd5, 1, 0, 5'd6, 1, 5'd7, 1, 0);
    #1 check("R9");
    @(negedge clk); // R3: second operand from memory
    drive(5'd1, 1, 5'd6, 1, 5'd5, 1, 0, 5'd6, 1, 5'd7, 1, 0);
    #1 check("R3");
    @(negedge clk); // R3: first operand from write-back
    drive(5'd7, 1, 5'd2, 1, 5'd5, 1, 0, 5'd6, 1, 5'd7, 1, 0);
    #1 check("R3");
    @(negedge clk); // R3: unused operand never forwarded
    drive(5'd7, 0, 5'd5, 0, 5'd5, 1, 0, 5'd6, 1, 5'd7, 1, 0);
    #1 check("R3");
    @(negedge clk); // R4: all three stages match
    drive(5'd9, 1, 5'd9, 1, 5'd9, 1, 0, 5'd9, 1, 5'd9, 1, 0);
    #1 check("R4");
    @(negedge clk); // R4: memory over write-back
    drive(5'd9, 1, 5'd9, 1, 5'd9, 0, 0, 5'd9, 1, 5'd9, 1, 0);
    #1 check("R4");
    @(negedge clk); // R2: zero index everywhere
    drive(5'd0, 1, 5'd0, 1, 5'd0, 1, 1, 5'd0, 1, 5'd0, 1, 0);
    #1 check("R2");
    @(negedge clk); // R6/R5: load hazard, memory also matches
    drive(5'd8, 1, 5'd1, 1, 5'd8, 1, 1, 5'd8, 1, 5'd2, 1, 0);
    #1 check("R6");
    check("R5");
    @(negedge clk); // R6: load matches an unused source
    drive(5'd1, 1, 5'd8, 0, 5'd8, 1, 1, 5'd3, 1, 5'd2, 1, 0);
    #1 check("R6");
    @(negedge clk); // R8: redirect beats a load hazard
    drive(5'd8, 1, 5'd1, 1, 5'd8, 1, 1, 5'd3, 0, 5'd2, 0, 1);
    #1 check("R8");
    @(negedge clk); // R8: redirect alone
    drive(5'd1, 1, 5'd1, 1, 5'd2, 0, 0, 5'd3, 0, 5'd2, 0, 1);
    #1 check("R8");

    // pipeline run: the model holds, bubbles and flushes as required
    dec = '0; ex = '0; mem = '0; wb = '0; prev_hold = 0;
    for (int c = 0; c < 3000; c++) begin
      logic [7:0] e;
      bit rdr;
      @(negedge clk);
      rdr = ($urandom_range(0, 9) == 0);
      drive(dec.rs, dec.ru, dec.rt, dec.tu, ex.rd, ex.we, ex.ld,
            mem.rd, mem.we, wb.rd, wb.we, rdr);
      #1;
      e = expect_now();
      check("R6");
      checks++;
      if (prev_hold && pc_hold) begin
        errors++;
        $display("FAIL R7: actual=hold again expected=no hold");
      end
      prev_hold = pc_hold;
      @(posedge clk);
      wb = mem; mem = ex;
      if (e[3]) begin
        ex = '0;
      end else begin
        ex = dec;
        dec = e[0] ? ins_t'('0) : rnd_ins();
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule